// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block holds the timing state of every bank behind a small DRAM controller and decides, each cycle, whether the command the scheduler is offering may issue. A command names a bank and is one of two kinds. An access carries a row-hit flag, a page-policy flag and a read/write flag. A precharge closes the bank's row. Every timing value is a parameter counted in controller clocks. The defaults are activate-to-column 11, column latency 11, precharge 11, minimum activate-to-precharge 33 and a burst of 4 clocks. Those are the values the requirements quote.

Each bank runs a four-state machine: `BK_IDLE` (no row open), `BK_OPENING` (activate in progress), `BK_OPEN` (row open) and `BK_CLOSING` (precharge in progress). The transitions are as follows.
- An open-page access takes `BK_IDLE` to `BK_OPENING`. A row-miss access from `BK_OPEN` does the same: its precharge comes first and its activate follows after the precharge time.
- `BK_OPENING` moves to `BK_OPEN` when its timer expires.
- A row-hit access keeps the bank in `BK_OPEN` for one burst.
- A precharge from `BK_OPEN`, or a close-page access from `BK_IDLE`, moves the bank to `BK_CLOSING`.
- `BK_CLOSING` moves to `BK_IDLE` when its timer expires.

Each bank keeps two saturating down-counters. One is the bank-free timer. The other is the minimum row-open timer, which is loaded at every activate and has its own parameter. A close-page access releases the bank at the later of two bounds: the minimum row-open time plus precharge, or the column path plus precharge.

Each bank also counts the bytes moved while its row is open. The count is handed out on a report channel whenever that row is closed. A write that must first precharge an open row holds the shared command bus until its activate. The scheduler offers a command with `req_valid`, and the command issues in any cycle where `req_valid` and `req_ready` are both high.

Top module: `dram_bank_timing`

## Requirements
- R1: After reset every bank is idle (`bank_open` all zero), `rpt_valid` and `cmd_bus_busy` are low, and `req_ready` is high for any command to any bank.
- R2: An access (`req_precharge`=0, `req_close_page`=0) to an idle bank issues at once and sets that bank's `bank_open` bit. The next command to that bank can issue no earlier than T_RCD+T_CL = 22 cycles later: offered in the cycle after issue, it waits exactly 22 cycles with `req_ready` low.
- R3: A precharge (`req_precharge`=1) to an open bank is held off, with `req_ready` low, until T_RAS = 33 clock edges have passed since that bank's activate.
- R4: A row-miss access (`req_row_hit`=0) to an open bank precharges first. Its activate falls T_RP cycles after issue. The bank is busy for T_RP+T_RCD+T_CL = 33 cycles, and a later precharge must wait T_RP+T_RAS = 44 edges from the issue.
- R5: A row-hit access (`req_row_hit`=1) to an open, non-busy bank issues even while T_RAS is still running. It keeps the row open and makes the bank busy for T_BURST = 4 cycles.
- R6: A close-page access (`req_close_page`=1) issues only to an idle bank and leaves `bank_open` low. It makes the bank busy for max(T_RAS, T_RCD+T_CL) + T_RP = 44 cycles. Offered to an open bank, it never sees `req_ready` high.
- R7: A row-miss write (`req_write`=1) to an open bank raises `cmd_bus_busy` for T_RP = 11 cycles. During that time `req_ready` is low for every bank.
- R8: Each bank counts BURST_BYTES = 64 bytes per access while its row is open, saturating at the counter width. A precharge or row miss reports that count on `rpt_bytes` with the bank on `rpt_bank`, and the count restarts. A close-page access reports exactly 64.
- R9: `rpt_valid` stays high with `rpt_bank` and `rpt_bytes` unchanged until `rpt_ready` is high. While a report is pending and `rpt_ready` is low, `req_ready` is low.
- R10: A precharge to an idle bank issues with no effect: no report, no timer load, and the bank stays idle. The precharge flag takes priority over the page-policy and row-hit flags.
- R11: Two activates to the same bank are at least T_RAS+T_RP = 44 clock edges apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Scheduler offers a command |
| req_ready | output | 1 | Offered command may issue this cycle |
| req_bank | input | BANK_W | Target bank of the command |
| req_precharge | input | 1 | 1 = precharge, 0 = access |
| req_close_page | input | 1 | Access uses close-page policy |
| req_row_hit | input | 1 | Access targets the row already open |
| req_write | input | 1 | Access is a write |
| rpt_valid | output | 1 | A closed row's byte count is available |
| rpt_ready | input | 1 | Consumer takes the report |
| rpt_bank | output | BANK_W | Bank whose row was closed |
| rpt_bytes | output | BYTE_W | Bytes moved while that row was open |
| bank_open | output | NUM_BANKS | Per bank: row open or being opened |
| cmd_bus_busy | output | 1 | Command bus held for a pending activate |

## Verification
On every cycle, the assertions check the row-open minimum before any precharge and the activate-to-activate spacing of each bank. They use an age counter that sits beside each bank machine. They also check that no bank is released from `BK_CLOSING` early, that no command issues to a busy bank or while the bus is held, and that a pending report stays stable. The exact wait counts can only be shown by the bench's scenarios: for example 10, 32 and 44 cycles in the cases above. The same holds for the byte totals reported after several hits, for a no-op precharge leaving everything untouched, and for a close-page access never issuing to an open bank. A cycle-by-cycle model compares every output through directed and random traffic.

// File: rtl/dram_tt_pkg.sv
package dram_tt_pkg;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPENING = 2'd1,
        BK_OPEN    = 2'd2,
        BK_CLOSING = 2'd3
    } bank_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_tt_bus.sv
module dram_tt_bus #(
    parameter int T_RP = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(T_RP + 1);
    localparam logic [CNT_W-1:0] LD_VAL = CNT_W'(T_RP);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // R7: a hold is only started when the bus is free
    p_load_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

endmodule

// File: rtl/dram_tt_report.sv
module dram_tt_report #(
    parameter int BANK_W = 2,
    parameter int BYTE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] load_bank,
    input  logic [BYTE_W-1:0] load_bytes,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BANK_W-1:0] out_bank,
    output logic [BYTE_W-1:0] out_bytes
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bank  <= '0;
            out_bytes <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_bank  <= load_bank;
            out_bytes <= load_bytes;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R9: a pending report is held unchanged until it is taken
    p_rpt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bank) && $stable(out_bytes)));

endmodule

// File: rtl/dram_tt_bank.sv
module dram_tt_bank
    import dram_tt_pkg::*;
#(
    parameter int T_RCD       = 11,
    parameter int T_CL        = 11,
    parameter int T_RP        = 11,
    parameter int T_RAS       = 33,
    parameter int T_BURST     = 4,
    parameter int BURST_BYTES = 64,
    parameter int BYTE_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              is_pre,
    input  logic              is_close,
    input  logic              row_hit,
    input  logic              is_write,
    output logic              can_issue,
    output logic              is_open,
    output logic              rpt_req,
    output logic [BYTE_W-1:0] rpt_val,
    output logic              bus_req
);
    localparam int CNT_W = $clog2(T_RP + T_RAS + T_RCD + T_CL + T_BURST + 2);
    localparam int CLOSE_HOLD = max2(T_RAS, T_RCD + T_CL) + T_RP;
    localparam logic [CNT_W-1:0] LD_OPEN  = CNT_W'(T_RCD + T_CL);
    localparam logic [CNT_W-1:0] LD_MISS  = CNT_W'(T_RP + T_RCD + T_CL);
    localparam logic [CNT_W-1:0] LD_CLOSE = CNT_W'(CLOSE_HOLD);
    localparam logic [CNT_W-1:0] LD_PRE   = CNT_W'(T_RP);
    localparam logic [CNT_W-1:0] LD_HIT   = CNT_W'(T_BURST);
    localparam logic [CNT_W-1:0] LD_RAS   = CNT_W'(T_RAS);
    localparam logic [CNT_W-1:0] LD_RASM  = CNT_W'(T_RP + T_RAS);
    localparam logic [BYTE_W-1:0] ONE_BURST = BYTE_W'(BURST_BYTES);

    bank_st_e          st_q, st_n;
    logic [CNT_W-1:0]  free_q, free_n;
    logic [CNT_W-1:0]  ras_q, ras_n;
    logic [BYTE_W-1:0] bytes_q, bytes_n;
    logic [BYTE_W:0]   bytes_sum;

    assign bytes_sum = {1'b0, bytes_q} + {1'b0, ONE_BURST};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= BK_IDLE;
            free_q  <= '0;
            ras_q   <= '0;
            bytes_q <= '0;
        end else begin
            st_q    <= st_n;
            free_q  <= free_n;
            ras_q   <= ras_n;
            bytes_q <= bytes_n;
        end
    end

    // next state and timer loads
    always_comb begin
        st_n    = st_q;
        free_n  = (free_q != '0) ? free_q - 1'b1 : '0;
        ras_n   = (ras_q  != '0) ? ras_q  - 1'b1 : '0;
        bytes_n = bytes_q;
        unique case (st_q)
            BK_IDLE: begin
                if (sel && !is_pre) begin
                    if (is_close) begin
                        st_n   = BK_CLOSING;
                        free_n = LD_CLOSE;
                    end else begin
                        st_n    = BK_OPENING;
                        free_n  = LD_OPEN;
                        ras_n   = LD_RAS;
                        bytes_n = ONE_BURST;
                    end
                end
            end
            BK_OPENING: begin
                if (free_q == CNT_W'(1)) st_n = BK_OPEN;
            end
            BK_OPEN: begin
                if (sel) begin
                    if (is_pre) begin
                        st_n    = BK_CLOSING;
                        free_n  = LD_PRE;
                        bytes_n = '0;
                    end else if (row_hit) begin
                        free_n  = LD_HIT;
                        bytes_n = bytes_sum[BYTE_W] ? '1 : bytes_sum[BYTE_W-1:0];
                    end else begin
                        st_n    = BK_OPENING;
                        free_n  = LD_MISS;
                        ras_n   = LD_RASM;
                        bytes_n = ONE_BURST;
                    end
                end
            end
            BK_CLOSING: begin
                if (free_q == CNT_W'(1)) st_n = BK_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        can_issue = 1'b0;
        is_open   = 1'b0;
        rpt_req   = 1'b0;
        rpt_val   = ONE_BURST;
        bus_req   = 1'b0;
        unique case (st_q)
            BK_IDLE: begin
                can_issue = 1'b1;
                rpt_req   = sel && !is_pre && is_close;
            end
            BK_OPENING: begin
                is_open = 1'b1;
            end
            BK_OPEN: begin
                is_open = 1'b1;
                rpt_val = bytes_q;
                if (free_q == '0) begin
                    if (is_pre)        can_issue = (ras_q == '0);
                    else if (is_close) can_issue = 1'b0;
                    else               can_issue = row_hit || (ras_q == '0);
                end
                rpt_req = sel && (is_pre || !row_hit);
                bus_req = sel && !is_pre && !row_hit && is_write;
            end
            BK_CLOSING: begin
                can_issue = 1'b0;
            end
        endcase
    end

    // ---------------- checker: age since the last activate ----------------
    localparam logic [CNT_W-1:0] AGE_CAP = CNT_W'(T_RAS + T_RP);

    logic [CNT_W-1:0] act_dly_q;
    logic [CNT_W-1:0] age_q;
    logic             seen_q;
    logic             act_evt;

    assign act_evt = (sel && (st_q == BK_IDLE) && !is_pre) ||
                     (act_dly_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_dly_q <= '0;
            age_q     <= '0;
            seen_q    <= 1'b0;
        end else begin
            if (sel && (st_q == BK_OPEN) && !is_pre && !row_hit)
                act_dly_q <= LD_PRE;
            else if (act_dly_q != '0)
                act_dly_q <= act_dly_q - 1'b1;
            if (act_evt) begin
                age_q  <= '0;
                seen_q <= 1'b1;
            end else if (age_q < AGE_CAP) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    // R11: activates to one bank are spaced by row-open minimum plus precharge
    p_act_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_evt && seen_q) |-> (age_q == AGE_CAP));

    // R3: a precharge never issues before the row-open minimum has passed
    p_pre_after_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && is_pre && (st_q == BK_OPEN)) |-> (age_q >= LD_RAS));

    // R6: a bank leaving precharge has covered both close bounds
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == BK_CLOSING) && (free_q == CNT_W'(1))) |=> (age_q == AGE_CAP));

    // R2: nothing issues to a bank that is still busy
    p_no_busy_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (((st_q == BK_IDLE) || (st_q == BK_OPEN)) && (free_q == '0)));

endmodule

// File: rtl/dram_bank_timing.sv
module dram_bank_timing #(
    parameter int NUM_BANKS   = 4,
    parameter int T_RCD       = 11,
    parameter int T_CL        = 11,
    parameter int T_RP        = 11,
    parameter int T_RAS       = 33,
    parameter int T_BURST     = 4,
    parameter int BURST_BYTES = 64,
    parameter int BYTE_W      = 16,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic                 req_precharge,
    input  logic                 req_close_page,
    input  logic                 req_row_hit,
    input  logic                 req_write,
    output logic                 rpt_valid,
    input  logic                 rpt_ready,
    output logic [BANK_W-1:0]    rpt_bank,
    output logic [BYTE_W-1:0]    rpt_bytes,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 cmd_bus_busy
);
    logic [NUM_BANKS-1:0] can_vec;
    logic [NUM_BANKS-1:0] sel_vec;
    logic [NUM_BANKS-1:0] rpt_req_vec;
    logic [NUM_BANKS-1:0] bus_req_vec;
    logic [BYTE_W-1:0]    rpt_val_arr [NUM_BANKS];
    logic                 can_sel;
    logic                 accept;
    logic [BYTE_W-1:0]    rpt_in;

    always_comb begin
        can_sel = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (req_bank == BANK_W'(b)) can_sel = can_vec[b];
    end

    assign req_ready = can_sel && !cmd_bus_busy && (!rpt_valid || rpt_ready);
    assign accept    = req_valid && req_ready;

    always_comb begin
        sel_vec = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            sel_vec[b] = accept && (req_bank == BANK_W'(b));
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            dram_tt_bank #(
                .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .T_RAS(T_RAS),
                .T_BURST(T_BURST), .BURST_BYTES(BURST_BYTES), .BYTE_W(BYTE_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .sel      (sel_vec[g]),
                .is_pre   (req_precharge),
                .is_close (req_close_page),
                .row_hit  (req_row_hit),
                .is_write (req_write),
                .can_issue(can_vec[g]),
                .is_open  (bank_open[g]),
                .rpt_req  (rpt_req_vec[g]),
                .rpt_val  (rpt_val_arr[g]),
                .bus_req  (bus_req_vec[g])
            );
        end
    endgenerate

    always_comb begin
        rpt_in = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (rpt_req_vec[b]) rpt_in = rpt_val_arr[b];
    end

    dram_tt_report #(.BANK_W(BANK_W), .BYTE_W(BYTE_W)) u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (|rpt_req_vec),
        .load_bank (req_bank),
        .load_bytes(rpt_in),
        .out_ready (rpt_ready),
        .out_valid (rpt_valid),
        .out_bank  (rpt_bank),
        .out_bytes (rpt_bytes)
    );

    dram_tt_bus #(.T_RP(T_RP)) u_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .load (|bus_req_vec),
        .busy (cmd_bus_busy)
    );

    // R7: a held command bus blocks every bank
    p_bus_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bus_busy |-> !req_ready);

    // R9: a stalled report blocks new commands
    p_rpt_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_ready) |-> !req_ready);

endmodule

// File: tb/tb_dram_bank_timing.sv
`timescale 1ns/1ps
module tb_dram_bank_timing;
    localparam int NB = 4;
    localparam int T_RCD = 11, T_CL = 11, T_RP = 11, T_RAS = 33, T_BURST = 4;
    localparam int BB = 64;
    localparam int BYTE_MAX = 65535;
    localparam int CLOSE_HOLD = ((T_RAS > T_RCD + T_CL) ? T_RAS : T_RCD + T_CL) + T_RP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_precharge = 1'b0, req_close_page = 1'b0;
    logic req_row_hit = 1'b0, req_write = 1'b0, rpt_ready = 1'b1;
    logic [1:0] req_bank = '0;
    logic req_ready, rpt_valid, cmd_bus_busy;
    logic [1:0] rpt_bank;
    logic [15:0] rpt_bytes;
    logic [NB-1:0] bank_open;

    always #5 clk = ~clk;

    dram_bank_timing dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_precharge(req_precharge),
        .req_close_page(req_close_page), .req_row_hit(req_row_hit),
        .req_write(req_write), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
        .rpt_bank(rpt_bank), .rpt_bytes(rpt_bytes), .bank_open(bank_open),
        .cmd_bus_busy(cmd_bus_busy)
    );

    int nchk = 0, nerr = 0;
    bit done = 0;

    // reference model: 0 idle, 1 opening, 2 open, 3 closing
    int mst[NB], mfr[NB], mras[NB], mby[NB];
    int mbus;
    bit mrv;
    int mrb, mrby;
    bit exp_ready, last_acc;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit mready(int b, bit pre, bit cls, bit hit);
        if (mbus > 0) return 0;
        if (mrv && !rpt_ready) return 0;
        if (mst[b] == 0) return 1;
        if (mst[b] != 2 || mfr[b] != 0) return 0;
        if (pre) return mras[b] == 0;
        if (cls) return 0;
        return hit || (mras[b] == 0);
    endfunction

    task automatic model_next(input bit acc);
        for (int b = 0; b < NB; b++) begin
            if (mfr[b] > 0) begin
                mfr[b]--;
                if (mfr[b] == 0) begin
                    if (mst[b] == 1) mst[b] = 2;
                    else if (mst[b] == 3) mst[b] = 0;
                end
            end
            if (mras[b] > 0) mras[b]--;
        end
        if (mbus > 0) mbus--;
        if (mrv && rpt_ready) mrv = 0;
        if (acc) begin
            int b = int'(req_bank);
            if (mst[b] == 0) begin
                if (!req_precharge && req_close_page) begin
                    mst[b] = 3; mfr[b] = CLOSE_HOLD;
                    mrv = 1; mrb = b; mrby = BB;
                end else if (!req_precharge) begin
                    mst[b] = 1; mfr[b] = T_RCD + T_CL; mras[b] = T_RAS; mby[b] = BB;
                end
            end else begin
                if (req_precharge) begin
                    mst[b] = 3; mfr[b] = T_RP;
                    mrv = 1; mrb = b; mrby = mby[b]; mby[b] = 0;
                end else if (req_row_hit) begin
                    mfr[b] = T_BURST;
                    mby[b] = (mby[b] + BB > BYTE_MAX) ? BYTE_MAX : mby[b] + BB;
                end else begin
                    mst[b] = 1; mfr[b] = T_RP + T_RCD + T_CL; mras[b] = T_RP + T_RAS;
                    mrv = 1; mrb = b; mrby = mby[b]; mby[b] = BB;
                    if (req_write) mbus = T_RP;
                end
            end
        end
    endtask

    task automatic compare();
        exp_ready = mready(int'(req_bank), req_precharge, req_close_page, req_row_hit);
        chk(req_ready == exp_ready, "R2/R3 model req_ready", req_ready, exp_ready);
        chk(cmd_bus_busy == (mbus > 0), "R7 model cmd_bus_busy", cmd_bus_busy, mbus > 0);
        chk(rpt_valid == mrv, "R9 model rpt_valid", rpt_valid, mrv);
        if (mrv) begin
            chk(rpt_bytes == mrby, "R8 model rpt_bytes", rpt_bytes, mrby);
            chk(rpt_bank == mrb, "R8 model rpt_bank", rpt_bank, mrb);
        end
        for (int b = 0; b < NB; b++)
            chk(bank_open[b] == (mst[b] == 1 || mst[b] == 2), "R2 model bank_open",
                bank_open[b], (mst[b] == 1 || mst[b] == 2));
    endtask

    task automatic tick();
        #1;
        compare();
        last_acc = req_valid && exp_ready;
        model_next(last_acc);
        @(negedge clk);
        #1;
    endtask

    task automatic issue(input int b, input bit pre, input bit cls, input bit hit,
                         input bit wr, output int w);
        req_bank = 2'(b); req_precharge = pre; req_close_page = cls;
        req_row_hit = hit; req_write = wr; req_valid = 1;
        w = 0;
        forever begin
            tick();
            if (last_acc) break;
            w++;
            if (w > 400) begin
                chk(0, "watchdog on issue", w, 0);
                break;
            end
        end
        req_valid = 0;
    endtask

    task automatic present(input int b, input bit pre, input bit cls, input int n,
                           output int hits);
        req_bank = 2'(b); req_precharge = pre; req_close_page = cls;
        req_row_hit = 0; req_write = 0; req_valid = 1;
        hits = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (last_acc) hits++;
        end
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        req_valid = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int w, w2, h;
        for (int b = 0; b < NB; b++) begin
            mst[b] = 0; mfr[b] = 0; mras[b] = 0; mby[b] = 0;
        end
        mbus = 0; mrv = 0; mrb = 0; mrby = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;

        // R1 reset state
        chk(bank_open == '0, "R1 bank_open after reset", bank_open, 0);
        chk(!rpt_valid, "R1 rpt_valid after reset", rpt_valid, 0);
        chk(!cmd_bus_busy, "R1 cmd_bus_busy after reset", cmd_bus_busy, 0);
        chk(req_ready, "R1 req_ready after reset", req_ready, 1);

        // R2 open on idle bank, then a hit waits for the column path
        issue(0, 0, 0, 0, 0, w);
        chk(w == 0, "R2 open idle bank wait", w, 0);
        chk(bank_open[0], "R2 bank_open set", bank_open[0], 1);
        issue(0, 0, 0, 1, 0, w);
        chk(w == T_RCD + T_CL, "R2 next command wait", w, T_RCD + T_CL);
        // R3 precharge held until row-open minimum
        issue(0, 1, 0, 0, 0, w);
        chk(w == T_RAS - (T_RCD + T_CL) - 1, "R3 precharge wait", w, T_RAS - (T_RCD + T_CL) - 1);
        chk(rpt_valid && rpt_bytes == 2 * BB, "R8 bytes after one hit", rpt_bytes, 2 * BB);

        // R10 precharge to an idle bank
        issue(1, 1, 1, 1, 0, w);
        chk(w == 0, "R10 idle precharge wait", w, 0);
        chk(!rpt_valid, "R10 no report", rpt_valid, 0);
        chk(!bank_open[1], "R10 bank stays idle", bank_open[1], 0);

        // R6 close-page access
        issue(2, 0, 1, 0, 0, w);
        chk(rpt_valid && rpt_bytes == BB, "R6 close-page report", rpt_bytes, BB);
        chk(!bank_open[2], "R6 bank_open stays low", bank_open[2], 0);
        issue(2, 0, 0, 0, 0, w);
        chk(w == CLOSE_HOLD, "R6 close-page hold", w, CLOSE_HOLD);
        present(2, 0, 1, 50, h);
        chk(h == 0, "R6 close-page to open bank never issues", h, 0);

        // R7 write miss holds the bus; R8 reports the old row
        issue(2, 0, 0, 0, 1, w);
        chk(cmd_bus_busy, "R7 bus busy after write miss", cmd_bus_busy, 1);
        chk(rpt_valid && rpt_bank == 2 && rpt_bytes == BB, "R8 miss report", rpt_bytes, BB);
        issue(3, 0, 0, 0, 0, w);
        chk(w == T_RP, "R7 other bank blocked", w, T_RP);
        // R4 precharge after a miss counts from the delayed activate
        issue(2, 1, 0, 0, 0, w);
        chk(w == T_RAS - 1, "R4 precharge after miss wait", w, T_RAS - 1);

        // R9 report backpressure
        idle(60);
        rpt_ready = 0;
        issue(3, 1, 0, 0, 0, w);
        present(1, 1, 0, 5, h);
        chk(h == 0, "R9 blocked while report pending", h, 0);
        chk(rpt_valid && rpt_bank == 3 && rpt_bytes == BB, "R9 report held", rpt_bytes, BB);
        rpt_ready = 1;
        issue(1, 1, 0, 0, 0, w);
        chk(w == 0, "R9 released by rpt_ready", w, 0);

        // R5 hits and R8 accumulation
        issue(1, 0, 0, 0, 0, w);
        issue(1, 0, 0, 1, 0, w);
        issue(1, 0, 0, 1, 0, w);
        chk(w == T_BURST, "R5 hit burst wait", w, T_BURST);
        issue(1, 0, 0, 1, 0, w);
        idle(40);
        issue(1, 1, 0, 0, 0, w);
        chk(rpt_valid && rpt_bytes == 4 * BB, "R8 four-access total", rpt_bytes, 4 * BB);

        // R11 activate spacing
        idle(20);
        issue(0, 0, 0, 0, 0, w);
        issue(0, 1, 0, 0, 0, w);
        issue(0, 0, 0, 0, 0, w2);
        chk((w + 1) + (w2 + 1) == T_RAS + T_RP + 2, "R11 activate spacing",
            (w + 1) + (w2 + 1), T_RAS + T_RP + 2);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            req_valid      = ($urandom_range(0, 1) == 1);
            req_bank       = 2'($urandom_range(0, NB - 1));
            req_precharge  = ($urandom_range(0, 4) == 0);
            req_close_page = ($urandom_range(0, 4) == 0);
            req_row_hit    = ($urandom_range(0, 1) == 1);
            req_write      = ($urandom_range(0, 1) == 1);
            rpt_ready      = ($urandom_range(0, 4) != 0);
            tick();
        end
        req_valid = 0;
        rpt_ready = 1;
        idle(5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule